// File: doc/BRIEF.md
# GPIO Output and Direction Register Bank

This block keeps the output levels, pin directions and driver enables for a GPIO controller of four banks. Banks 0, 2 and 3 have 32 pins and bank 1 has 22. A 32-bit register bus writes and reads the state. Each bank has two masked data-write addresses, one for its lower sixteen pins and one for its upper sixteen. In the word written to either of them, bits 31:16 select which pins keep their value and bits 15:0 give the new levels. Software can therefore change any single pin in one write, without reading first. Each bank also has a read-only input register that shows the raw pin levels, a direction register and an output-enable register. The block drives a flat output-value bus and a flat tri-state enable bus toward the pads.

Requests travel on a valid-qualified channel with no back-pressure. The block takes a request in every cycle where `req_valid` is high. A read request is answered in the next cycle by `rsp_valid` with `rsp_rdata`. The requester must always accept that response; there is no ready signal in either direction.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, `pin_out` and `pin_oe` are all 0. Every direction register reads 0, except that bank 0 reads 0x00000180.
- R2: A write to byte address 8·b (low half of bank b) updates pins 0..15. For each k, pin k takes wdata bit k when wdata bit 16+k is 0, and keeps its value when that bit is 1.
- R3: A write to byte address 8·b+4 (high half of bank b) updates pins 16..31 under the same rule: wdata bit 16+k is the keep bit for pin 16+k, and wdata bit k is its level.
- R4: A read of either masked data address returns that half's current output levels in bits 15:0. Bits 31:16 read as 0.
- R5: Address 0x060+4·b reads the levels on bank b's `pin_in` bits, one bit per pin. Writes to that address change nothing.
- R6: The direction register of bank b is at 0x204+0x40·b and its output-enable register is at 0x208+0x40·b. Both are read/write, and bit i belongs to pin i.
- R7: `pin_oe` for a pin is 1 only when both its direction bit and its output-enable bit are 1.
- R8: Bits 22..31 of bank 1 do not exist. They read 0 in every register, ignore writes, and keep `pin_out`/`pin_oe` bits 54..63 at 0.
- R9: Direction bits 7 and 8 of bank 0 always read 1, whatever value is written to them.
- R10: Each read request produces exactly one `rsp_valid` pulse in the following cycle, and a write produces none. Unmapped addresses read 0 and ignore writes. Reads change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle; it is always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data is valid; one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| pin_in | input | 128 | Raw pin levels; bank b uses bits 32·b+31..32·b |
| pin_out | output | 128 | Output levels, same bank layout |
| pin_oe | output | 128 | Tri-state enables, same bank layout |

## Verification
A register written in one cycle can be read in the very next cycle. In that case the read must see the value just written, and its response must come back while the new level is already on `pin_out`. The bench provokes this by issuing a masked write and a read of the same half on consecutive clock edges, with no idle cycle between them. Both the read data and the pins are judged against an arithmetic model of the merge. Sweeps through every pin of every half, every bank's direction/enable patterns and the unmapped addresses cover the remaining behaviour.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BANK_PINS    = 32;
  localparam int HALF_PINS    = BANK_PINS / 2;
  localparam int DATA_STRIDE  = 8;
  localparam int HIGH_OFFSET  = 4;
  localparam int INPUT_BASE   = 'h060;
  localparam int INPUT_STRIDE = 4;
  localparam int DIR_BASE     = 'h204;
  localparam int OE_BASE      = 'h208;
  localparam int CFG_STRIDE   = 'h40;

  typedef enum logic [2:0] {
    K_NONE, K_DATA_LO, K_DATA_HI, K_INPUT, K_DIR, K_OE
  } reg_kind_e;

  // pins that exist in bank b
  function automatic logic [BANK_PINS-1:0] impl_mask(int b);
    return (b == 1) ? 32'h003F_FFFF : 32'hFFFF_FFFF;
  endfunction

  // pins whose direction is hard-wired to output
  function automatic logic [BANK_PINS-1:0] fixed_out(int b);
    return (b == 0) ? 32'h0000_0180 : 32'h0000_0000;
  endfunction

  // keep bit 1 retains old level, keep bit 0 takes new level
  function automatic logic [HALF_PINS-1:0] merge_half(
    logic [HALF_PINS-1:0] old_v, logic [HALF_PINS-1:0] keep,
    logic [HALF_PINS-1:0] new_v);
    return (old_v & keep) | (new_v & ~keep);
  endfunction
endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_bank_pkg::*;
#(
  parameter int NB = 4,
  parameter int AW = 12,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [AW-1:0] addr,
  output reg_kind_e     kind,
  output logic [BW-1:0] bank
);
  always_comb begin
    kind = K_NONE;
    bank = '0;
    for (int b = 0; b < NB; b++) begin
      if (32'(addr) == DATA_STRIDE * b) begin
        kind = K_DATA_LO; bank = BW'(b);
      end else if (32'(addr) == DATA_STRIDE * b + HIGH_OFFSET) begin
        kind = K_DATA_HI; bank = BW'(b);
      end else if (32'(addr) == INPUT_BASE + INPUT_STRIDE * b) begin
        kind = K_INPUT; bank = BW'(b);
      end else if (32'(addr) == DIR_BASE + CFG_STRIDE * b) begin
        kind = K_DIR; bank = BW'(b);
      end else if (32'(addr) == OE_BASE + CFG_STRIDE * b) begin
        kind = K_OE; bank = BW'(b);
      end
    end
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter logic [BANK_PINS-1:0] IMPL  = '1,
  parameter logic [BANK_PINS-1:0] FIXED = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  reg_kind_e            kind,
  input  logic [31:0]          wdata,
  input  logic [BANK_PINS-1:0] pin_in,
  output logic [BANK_PINS-1:0] out_lvl,
  output logic [BANK_PINS-1:0] dir_lvl,
  output logic [BANK_PINS-1:0] drv_en,
  output logic [31:0]          rd_word
);
  logic [BANK_PINS-1:0] out_q, dir_q, oe_q;
  logic [HALF_PINS-1:0] keep, nval;

  assign keep = wdata[31:16];
  assign nval = wdata[15:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= FIXED & IMPL;
      oe_q  <= '0;
    end else if (wr_en) begin
      unique case (kind)
        K_DATA_LO: out_q[HALF_PINS-1:0] <=
          merge_half(out_q[HALF_PINS-1:0], keep, nval) & IMPL[HALF_PINS-1:0];
        K_DATA_HI: out_q[BANK_PINS-1:HALF_PINS] <=
          merge_half(out_q[BANK_PINS-1:HALF_PINS], keep, nval)
          & IMPL[BANK_PINS-1:HALF_PINS];
        K_DIR:     dir_q <= (wdata | FIXED) & IMPL;
        K_OE:      oe_q  <= wdata & IMPL;
        default:   ;
      endcase
    end
  end

  always_comb begin
    unique case (kind)
      K_DATA_LO: rd_word = {16'h0, out_q[HALF_PINS-1:0]};
      K_DATA_HI: rd_word = {16'h0, out_q[BANK_PINS-1:HALF_PINS]};
      K_INPUT:   rd_word = pin_in & IMPL;
      K_DIR:     rd_word = dir_q;
      K_OE:      rd_word = oe_q;
      default:   rd_word = '0;
    endcase
  end

  assign out_lvl = out_q;
  assign dir_lvl = dir_q;
  assign drv_en  = dir_q & oe_q;
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic                           req_write,
  input  logic [ADDR_W-1:0]              req_addr,
  input  logic [31:0]                    req_wdata,
  output logic                           rsp_valid,
  output logic [31:0]                    rsp_rdata,
  input  logic [NUM_BANKS*BANK_PINS-1:0] pin_in,
  output logic [NUM_BANKS*BANK_PINS-1:0] pin_out,
  output logic [NUM_BANKS*BANK_PINS-1:0] pin_oe
);
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  reg_kind_e                      kind;
  logic [BW-1:0]                  sel_bank;
  logic [31:0]                    rd_word [NUM_BANKS];
  logic [NUM_BANKS*BANK_PINS-1:0] dir_all;
  logic [31:0]                    rdata_d;

  gpio_reg_decode #(.NB(NUM_BANKS), .AW(ADDR_W)) u_dec (
    .addr(req_addr), .kind(kind), .bank(sel_bank)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic wr_en;
    assign wr_en = req_valid && req_write && (sel_bank == BW'(b));
    gpio_bank_regs #(.IMPL(impl_mask(b)), .FIXED(fixed_out(b))) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .kind    (kind),
      .wdata   (req_wdata),
      .pin_in  (pin_in[b*BANK_PINS +: BANK_PINS]),
      .out_lvl (pin_out[b*BANK_PINS +: BANK_PINS]),
      .dir_lvl (dir_all[b*BANK_PINS +: BANK_PINS]),
      .drv_en  (pin_oe[b*BANK_PINS +: BANK_PINS]),
      .rd_word (rd_word[b])
    );
  end

  assign rdata_d = (kind == K_NONE) ? 32'h0 : rd_word[sel_bank];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int NB = 4,
  parameter int AW = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_write,
  input logic [AW-1:0]   req_addr,
  input logic [15:0]     keep_bits,
  input logic            rsp_valid,
  input logic [NB*32-1:0] pin_out,
  input logic [NB*32-1:0] pin_oe,
  input logic [NB*32-1:0] dir_all
);
  assert_rsp_follows_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  assert_read_no_side_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> ($stable(pin_out) && $stable(pin_oe)));

  assert_full_keep_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == '0 && keep_bits == 16'hFFFF)
      |=> $stable(pin_out[15:0]));

  assert_input_write_inert_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == AW'(12'h060))
      |=> ($stable(pin_out) && $stable(pin_oe)));

  assert_oe_needs_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~dir_all) == '0);

  assert_bank1_hole_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out[63:54] == '0) && (pin_oe[63:54] == '0));

  assert_fixed_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dir_all[8:7] == 2'b11);
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NB(NUM_BANKS), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .keep_bits(req_wdata[31:16]), .rsp_valid(rsp_valid),
  .pin_out(pin_out), .pin_oe(pin_oe), .dir_all(dir_all)
);

// File: tb/sim_gpio_bank_ctrl.sv
module sim_gpio_bank_ctrl;
  localparam int NB = 4;
  localparam int W  = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [11:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [W-1:0]  pin_in = '0;
  logic [W-1:0]  pin_out, pin_oe;

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  logic [31:0] m_out [NB];
  logic [31:0] m_dir [NB];
  logic [31:0] m_oe  [NB];

  always #2 clk = ~clk;

  gpio_bank_ctrl #(.NUM_BANKS(NB), .ADDR_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [31:0] impl(int b);
    return (b == 1) ? 32'h003F_FFFF : 32'hFFFF_FFFF;
  endfunction
  function automatic logic [31:0] fixd(int b);
    return (b == 0) ? 32'h0000_0180 : 32'h0;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model_write(logic [11:0] a, logic [31:0] d);
    for (int b = 0; b < NB; b++) begin
      for (int h = 0; h < 2; h++)
        if (int'(a) == 8*b + 4*h)
          for (int k = 0; k < 16; k++)
            if (!d[16+k]) m_out[b][16*h+k] = d[k];
      m_out[b] &= impl(b);
      if (int'(a) == 'h204 + 'h40*b) m_dir[b] = (d | fixd(b)) & impl(b);
      if (int'(a) == 'h208 + 'h40*b) m_oe[b]  = d & impl(b);
    end
  endfunction

  function automatic logic [31:0] model_read(logic [11:0] a);
    for (int b = 0; b < NB; b++) begin
      if (int'(a) == 8*b)           return {16'h0, m_out[b][15:0]};
      if (int'(a) == 8*b + 4)       return {16'h0, m_out[b][31:16]};
      if (int'(a) == 'h060 + 4*b)   return pin_in[32*b +: 32] & impl(b);
      if (int'(a) == 'h204 + 'h40*b) return m_dir[b];
      if (int'(a) == 'h208 + 'h40*b) return m_oe[b];
    end
    return 32'h0;
  endfunction

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    #1 req_valid = 1'b0;
    model_write(a, d);
  endtask

  task automatic bus_read_check(string tag, logic [11:0] a);
    logic [31:0] exp;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp = model_read(a);
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    check({tag, " rsp_valid"}, W'(rsp_valid), W'(1'b1));
    check(tag, W'(rsp_rdata), W'(exp));
  endtask

  task automatic check_pins(string tag);
    logic [W-1:0] eo, ee;
    for (int b = 0; b < NB; b++) begin
      eo[32*b +: 32] = m_out[b];
      ee[32*b +: 32] = m_dir[b] & m_oe[b];
    end
    @(negedge clk);
    check({tag, " pin_out"}, pin_out, eo);
    check({tag, " pin_oe"}, pin_oe, ee);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : main
    for (int b = 0; b < NB; b++) begin
      m_out[b] = '0; m_dir[b] = fixd(b); m_oe[b] = '0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    check_pins("R1 reset");
    for (int b = 0; b < NB; b++) bus_read_check("R1 dir reset", 12'('h204 + 'h40*b));

    // R2 / R3 / R4 single-pin sweep through every half of every bank
    for (int b = 0; b < NB; b++)
      for (int h = 0; h < 2; h++)
        for (int i = 0; i < 16; i++) begin
          logic [15:0] keep;
          keep = ~(16'(1) << i);
          bus_write(12'(8*b + 4*h), {keep, 16'hFFFF});
          if (h == 0) check_pins("R2 single pin set");
          else        check_pins("R3 single pin set");
          bus_read_check("R4 half readback", 12'(8*b + 4*h));
        end
    // clear alternate pins, then full-pattern writes with no keep bits
    for (int b = 0; b < NB; b++)
      for (int h = 0; h < 2; h++) begin
        bus_write(12'(8*b + 4*h), {16'h5555, 16'h0000});
        check_pins(h == 0 ? "R2 masked clear" : "R3 masked clear");
        bus_write(12'(8*b + 4*h), {16'h0000, 16'hA5C3 ^ 16'(b*16'h1111 + h)});
        check_pins(h == 0 ? "R2 full write" : "R3 full write");
        bus_write(12'(8*b + 4*h), {16'hFFFF, 16'h0000});
        check_pins("R2 all keep no change");
        bus_read_check("R4 half after pattern", 12'(8*b + 4*h));
      end

    // R6 / R7 / R9 direction and enable patterns
    for (int b = 0; b < NB; b++) begin
      logic [31:0] pats [4];
      pats[0] = 32'h0; pats[1] = 32'hFFFF_FFFF;
      pats[2] = 32'h5A5A_33CC ^ 32'(b); pats[3] = 32'h0F0F_F0F0;
      for (int p = 0; p < 4; p++) begin
        bus_write(12'('h204 + 'h40*b), pats[p]);
        bus_write(12'('h208 + 'h40*b), pats[3-p]);
        check_pins("R7 oe is dir and enable");
        bus_read_check("R6 dir readback R9", 12'('h204 + 'h40*b));
        bus_read_check("R6 oe readback", 12'('h208 + 'h40*b));
      end
    end
    bus_write(12'h204, 32'h0);
    bus_read_check("R9 fixed outputs read 1", 12'h204);

    // R8 bank-1 missing pins
    bus_write(12'h00C, 32'h0000_FFFF);
    bus_write(12'h244, 32'hFFFF_FFFF);
    bus_write(12'h248, 32'hFFFF_FFFF);
    check_pins("R8 bank1 upper quiet");
    bus_read_check("R8 bank1 high half", 12'h00C);
    bus_read_check("R8 bank1 dir", 12'h244);

    // R5 input readback and ignored writes
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      pin_in = {32'hDEAD_BEEF ^ 32'(p), 32'h1234_5678 << p,
                32'hFFFF_FFFF >> p, 32'hC0DE_0001 ^ 32'(p*7)};
      for (int b = 0; b < NB; b++) bus_read_check("R5 input level", 12'('h060 + 4*b));
    end
    bus_write(12'h060, 32'hFFFF_FFFF);
    check_pins("R5 input write ignored");
    bus_read_check("R5 input after write", 12'h060);

    // R10 unmapped addresses and response timing
    bus_write(12'h020, 32'h0000_FFFF);
    bus_write(12'h304, 32'hFFFF_FFFF);
    bus_write(12'h070, 32'hFFFF_FFFF);
    check_pins("R10 unmapped write ignored");
    bus_read_check("R10 unmapped read zero", 12'h020);
    bus_read_check("R10 unmapped read zero", 12'h3FC);
    bus_write(12'h010, 32'h0000_1234);
    @(negedge clk);
    check("R10 no rsp after write", W'(rsp_valid), W'(1'b0));

    // back-to-back write then read of the same half
    for (int b = 0; b < NB; b++) begin
      bus_write(12'(8*b + 4), {16'h00FF, 16'(16'h9A00 + b)});
      bus_read_check("R3 read right after write", 12'(8*b + 4));
      check_pins("R3 pins after back-to-back");
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule